// File: doc/BRIEF.md
# Bus START/STOP Condition Detector

This block watches the two lines of an I2C bus (clock SCL and data SDA) with the system clock. It reports a START when SDA falls while SCL is high, and a STOP when SDA rises while SCL is high. A transition counts only when it is clean: SCL must have been high long enough, SDA must have been stable long enough before the transition, and both lines must hold their levels long enough after it. A bus-busy flag goes to 1 on an accepted START and back to 0 on an accepted STOP. This flag, and a one-cycle pulse that names the condition, change after a fixed latency from the transition, not at the transition itself.

The timing has two modes. In standard mode a 5-bit setting N sets every window. Only even, nonzero N is meaningful. An odd N is raised to the next even value, and zero acts as 2. The result is called Ne below. In fast mode the windows are fixed and N is ignored. When a STOP is accepted while the block is not bus master, it also raises a one-cycle interrupt request.

Top module: `i2c_cond_detect`

## Requirements
- R1: While and after reset, before any accepted condition, `bus_busy`, `start_det`, `stop_det` and `slave_stop_irq` are 0.
- R2: An SDA fall (1 to 0) with SCL high that meets every timing check sets `bus_busy` to 1 and gives a one-cycle `start_det` pulse in the same cycle.
- R3: An SDA rise (0 to 1) with SCL high that meets every timing check clears `bus_busy` to 0 and gives a one-cycle `stop_det` pulse in the same cycle.
- R4: An SDA transition is ignored unless synchronized SCL has been high for at least REL cycles before it. REL is Ne in standard mode.
- R5: An SDA transition is ignored unless SDA was stable for at least SET cycles before it. SET is Ne+1 in standard mode.
- R6: An SDA transition is dropped if, within HOLD cycles after it, SCL goes low or SDA changes again. HOLD is Ne in standard mode.
- R7: In standard mode, count the rising clock edge that first samples the new SDA level as edge 1. `bus_busy` and the pulse then change at edge Ne+4. This is two synchronizer stages plus a flag latency of Ne+2 cycles.
- R8: With `fast_mode`=1, the windows are REL=4, SET=2, HOLD=2 and the flag latency is 4, so outputs change at edge 6. `cond_time` has no effect in this mode.
- R9: An odd `cond_time` behaves like the next even value (3 as 4, 31 as 32), and 0 behaves like 2.
- R10: `slave_stop_irq` pulses with `stop_det` only when `master` was 0. It stays 0 when `master` is 1.
- R11: SDA changes while SCL is low leave `bus_busy` unchanged and produce no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_in | input | 1 | Bus clock line, asynchronous |
| sda_in | input | 1 | Bus data line, asynchronous |
| fast_mode | input | 1 | 1 selects the fixed fast-mode windows |
| cond_time | input | 5 | Standard-mode timing value N |
| master | input | 1 | 1 when the local controller is bus master |
| bus_busy | output | 1 | Bus-busy flag |
| start_det | output | 1 | One-cycle pulse on accepted START |
| stop_det | output | 1 | One-cycle pulse on accepted STOP |
| slave_stop_irq | output | 1 | One-cycle interrupt request on STOP in slave mode |

## Verification
Each accepted condition becomes visible Ne+4 rising edges after the SDA change is first sampled in standard mode, and 6 edges after in fast mode. For every latency case, the bench drives SDA just after a falling edge and counts falling edges. It checks that the flag is unchanged one edge early, that flag and pulse appear at the exact edge, and that the pulse is gone one edge later. For conditions that must be rejected, the bench holds the lines for 40 cycles, which is longer than any latency, and then reads the flag.

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect #(
  parameter int CFG_W       = 5,
  parameter int SYNC_STAGES = 2,
  parameter int FAST_REL    = 4,
  parameter int FAST_SET    = 2,
  parameter int FAST_HOLD   = 2,
  parameter int FAST_FLAG   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_in,
  input  logic             sda_in,
  input  logic             fast_mode,
  input  logic [CFG_W-1:0] cond_time,
  input  logic             master,
  output logic             bus_busy,
  output logic             start_det,
  output logic             stop_det,
  output logic             slave_stop_irq
);
  localparam int CW = CFG_W + 2;

  logic [SYNC_STAGES-1:0] scl_sr, sda_sr;
  logic                   sda_q;
  logic [CW-1:0]          scl_hi, sda_st, pcnt;
  logic                   pend, is_stop;
  logic [CW-1:0]          n_eff, rel_lim, set_lim, hold_lim, flag_lim;

  wire scl_s    = scl_sr[SYNC_STAGES-1];
  wire sda_s    = sda_sr[SYNC_STAGES-1];
  wire sda_edge = sda_s != sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sr <= '1;
      sda_sr <= '1;
      sda_q  <= 1'b1;
    end else begin
      scl_sr <= {scl_sr[SYNC_STAGES-2:0], scl_in};
      sda_sr <= {sda_sr[SYNC_STAGES-2:0], sda_in};
      sda_q  <= sda_s;
    end
  end

  always_comb begin
    if (cond_time == '0) n_eff = CW'(2);
    else                 n_eff = CW'(cond_time) + CW'(cond_time[0]);
    rel_lim  = fast_mode ? CW'(FAST_REL)  : n_eff;
    set_lim  = fast_mode ? CW'(FAST_SET)  : n_eff + CW'(1);
    hold_lim = fast_mode ? CW'(FAST_HOLD) : n_eff;
    flag_lim = fast_mode ? CW'(FAST_FLAG) : n_eff + CW'(2);
  end

  wire hold_ok = pcnt >= hold_lim;
  wire accept  = sda_edge && scl_s && (scl_hi >= rel_lim) &&
                 (sda_st >= set_lim) && !(pend && hold_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_hi <= '0;
      sda_st <= '0;
    end else begin
      if (!scl_s)            scl_hi <= '0;
      else if (scl_hi != '1) scl_hi <= scl_hi + CW'(1);
      if (sda_edge)          sda_st <= '0;
      else if (sda_st != '1) sda_st <= sda_st + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend           <= 1'b0;
      pcnt           <= '0;
      is_stop        <= 1'b0;
      bus_busy       <= 1'b0;
      start_det      <= 1'b0;
      stop_det       <= 1'b0;
      slave_stop_irq <= 1'b0;
    end else begin
      start_det      <= 1'b0;
      stop_det       <= 1'b0;
      slave_stop_irq <= 1'b0;
      if (accept) begin
        pend    <= 1'b1;
        pcnt    <= CW'(1);
        is_stop <= sda_s;
      end else if (pend) begin
        if (!hold_ok && (sda_edge || !scl_s)) begin
          pend <= 1'b0;
        end else if (pcnt == flag_lim - CW'(1)) begin
          pend           <= 1'b0;
          bus_busy       <= !is_stop;
          start_det      <= !is_stop;
          stop_det       <= is_stop;
          slave_stop_irq <= is_stop && !master;
        end else begin
          pcnt <= pcnt + CW'(1);
        end
      end
    end
  end

  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) start_det |-> bus_busy); // R2
  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) start_det |=> !start_det); // R2
  AST_STOP_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) stop_det |-> !bus_busy); // R3
  AST_BUSY_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_busy != $past(bus_busy)) |-> (start_det || stop_det)); // R7
  AST_IRQ_SLAVE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    slave_stop_irq |-> (stop_det && !$past(master))); // R10
  AST_SCL_LOW_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_edge && !scl_s && !pend) |=> !pend); // R11
endmodule

// File: tb/i2c_cond_detect_bench.sv
module i2c_cond_detect_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda = 1'b1, fast = 1'b0, master = 1'b0;
  logic [4:0] cond_time = 5'd4;
  logic bus_busy, start_det, stop_det, irq;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_cond_detect u_i2c_cond_detect (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda), .fast_mode(fast),
    .cond_time(cond_time), .master(master), .bus_busy(bus_busy),
    .start_det(start_det), .stop_det(stop_det), .slave_stop_irq(irq));

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic go_idle();
    scl = 1'b0; wait_n(2);
    sda = 1'b1; wait_n(2);
    scl = 1'b1; wait_n(60);
  endtask

  task automatic edge_latency(input bit new_sda, input int lat, input bit exp_irq, input string req);
    bit b0 = bus_busy;
    bit exp_b = !new_sda;
    sda = new_sda;
    wait_n(lat + 1);
    check(bus_busy == b0, req, "flag changed early", bus_busy, b0);
    wait_n(1);
    check(bus_busy == exp_b, req, "flag at due edge", bus_busy, exp_b);
    check((new_sda ? stop_det : start_det) == 1'b1, req, "pulse at due edge", new_sda ? stop_det : start_det, 1);
    check(irq == exp_irq, "R10", "irq at due edge", irq, exp_irq);
    wait_n(1);
    check(start_det == 1'b0 && stop_det == 1'b0 && irq == 1'b0, req, "pulse one cycle", start_det | stop_det | irq, 0);
  endtask

  task automatic t_pair(input int lat, input bit exp_irq, input string req);
    go_idle();
    edge_latency(1'b0, lat, 1'b0, req);
    wait_n(60);
    edge_latency(1'b1, lat, exp_irq, req);
  endtask

  task automatic t_release_fail();
    go_idle();
    scl = 1'b0; wait_n(2);
    scl = 1'b1; wait_n(1);
    sda = 1'b0; wait_n(40);
    check(bus_busy == 1'b0, "R4", "short SCL high accepted", bus_busy, 0);
  endtask

  task automatic t_setup_fail();
    go_idle();
    scl = 1'b0; wait_n(2);
    sda = 1'b0; wait_n(2);
    scl = 1'b1; wait_n(60);
    sda = 1'b1; wait_n(1);
    sda = 1'b0; wait_n(40);
    check(bus_busy == 1'b0, "R5", "short SDA setup accepted", bus_busy, 0);
  endtask

  task automatic t_hold_fail();
    go_idle();
    sda = 1'b0; wait_n(1);
    scl = 1'b0; wait_n(40);
    check(bus_busy == 1'b0, "R6", "short hold accepted", bus_busy, 0);
  endtask

  task automatic t_scl_low();
    bit seen = 1'b0;
    go_idle();
    edge_latency(1'b0, 6, 1'b0, "R2");
    scl = 1'b0; wait_n(3);
    for (int i = 0; i < 6; i++) begin
      sda = ~sda;
      for (int k = 0; k < 8; k++) begin
        wait_n(1);
        if (start_det || stop_det) seen = 1'b1;
      end
    end
    check(bus_busy == 1'b1 && !seen, "R11", "SDA moves with SCL low", bus_busy, 1);
    sda = 1'b0; wait_n(2);
    scl = 1'b1; wait_n(60);
    edge_latency(1'b1, 6, 1'b1, "R3");
  endtask

  task automatic t_fast();
    fast = 1'b1; cond_time = 5'd24;
    go_idle();
    scl = 1'b0; wait_n(2);
    scl = 1'b1; wait_n(8);
    edge_latency(1'b0, 4, 1'b0, "R8");
    wait_n(60);
    edge_latency(1'b1, 4, 1'b1, "R8");
    fast = 1'b0;
  endtask

  initial begin
    wait_n(5);
    check(bus_busy == 0 && start_det == 0 && stop_det == 0 && irq == 0, "R1", "outputs in reset", bus_busy, 0);
    rst_n = 1'b1;
    wait_n(60);
    check(bus_busy == 0 && start_det == 0 && stop_det == 0 && irq == 0, "R1", "outputs after reset", bus_busy, 0);
    cond_time = 5'd4;  t_pair(6, 1'b1, "R7");
    master = 1'b1;     t_pair(6, 1'b0, "R10");
    master = 1'b0;
    cond_time = 5'd24; t_pair(26, 1'b1, "R7");
    cond_time = 5'd3;  t_pair(6, 1'b1, "R9");
    cond_time = 5'd0;  t_pair(4, 1'b1, "R9");
    cond_time = 5'd31; t_pair(34, 1'b1, "R9");
    cond_time = 5'd4;
    t_release_fail();
    t_setup_fail();
    t_hold_fail();
    t_scl_low();
    t_fast();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule